// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral and Status Tracker

This block sits beside the transmit data path of a half-duplex CSMA/CD MAC. It holds a pending frame until the shared medium has been quiet for a full inter-packet gap. It grants the medium to the data path, watches for collisions, and schedules a counter-based backoff before each retry. While it does this it gathers the per-frame transmit error flags into one status word and pulses a done strobe when the frame's outcome is final.

One clock cycle stands for one bit time. The gap, slot time, retry limit, excessive-deferral limit and SQE-test window are parameters. When the data path reports a transmit FIFO underrun, the block tells it how to spoil the frame so that no receiver accepts it. A frame that is still shorter than one slot is cut short as a runt. A longer frame is finished with a deliberately bad FCS.

A gap may optionally be split in two after a received frame. Carrier seen in the first two thirds of that gap restarts it. Carrier seen in the final third is ignored.

Top module: `tx_defer_tracker`

## Requirements
- R1: While reset is active and on the first cycle after it, `tx_grant` is 0, `tx_corrupt` is 0, `stat_done` is 0 and `tx_stat` is all zeros.
- R2: A request is taken at the first clock edge that samples `tx_req` high while the block is idle. `tx_grant` rises IPG_BITS cycles after the later of two edges: the edge that took the request, and the last edge that sampled carrier high. When `two_part` is 0, the edge just before the grant never samples carrier high.
- R3: With `two_part` at 1, carrier sampled while fewer than IPG_BITS*2/3 gap cycles have elapsed restarts the gap. Carrier sampled after that point leaves the grant time unchanged. With `two_part` at 0, carrier anywhere in the gap restarts it.
- R4: `tx_stat[0]` (deferred) is set when carrier was sampled high at request acceptance or during the wait. `tx_stat[1]` (excessive deferral) is set when more than EXDEF_BITS wait cycles passed before the first grant.
- R5: `tx_stat[2]` (loss of carrier) is set when carrier falls while granted and no collision is present.
- R6: A collision while granted, after SLOT_BITS or more granted cycles, sets `tx_stat[3]` (late collision). The grant ends at once, no retry follows, and the frame completes.
- R7: A collision earlier in the grant ends the attempt and starts a backoff, then a new gap. `tx_stat[8 +: CW]` holds the collision count. `tx_stat[5]` means exactly one collision and `tx_stat[6]` means more than one. When the count reaches RETRY_LIMIT, `tx_stat[7]` is set instead, the frame is abandoned, and bits 5 and 6 read 0.
- R8: When `mode_10m` is 1 at request acceptance and the frame ends normally, `tx_stat[4]` (SQE-test error) is set if `sqe_pulse` is not seen within SQE_WIN cycles after the end. In 100 Mbps mode bit 4 stays 0.
- R9: An underrun while granted, before SLOT_BITS granted cycles, drives `tx_corrupt`=2'b01 (truncate) for one cycle with the grant still high, and the grant drops on the next cycle. A later underrun drives `tx_corrupt`=2'b10 (bad FCS) and holds it until `tx_end` ends the grant. `tx_corrupt` is nonzero only while granted.
- R10: `stat_done` is high for exactly one cycle per frame. `tx_stat` is cleared when the next request is accepted and is otherwise unchanged while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Frame ready to send |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| tx_end | input | 1 | Data path has sent the last bit |
| fifo_underrun | input | 1 | Transmit FIFO ran empty |
| mode_10m | input | 1 | 10 Mbps mode, enables the SQE-test check |
| two_part | input | 1 | Use the split gap |
| sqe_pulse | input | 1 | SQE test signal from the transceiver |
| tx_grant | output | 1 | Data path may transmit |
| tx_corrupt | output | 2 | 00 none, 01 truncate as runt, 10 send bad FCS |
| stat_done | output | 1 | One-cycle frame-complete strobe |
| tx_stat | output | 8+CW | Status word, CW = $clog2(RETRY_LIMIT+1) |

## Verification
On every cycle, the assertions check the following. The grant never follows an edge that sampled carrier in plain-gap mode. The done strobe never lasts two cycles. The status word never moves while idle. The corrupt command appears only under a grant and follows any unanswered underrun. A late collision always ends the frame. The retry-class bits are never both set. The SQE error never appears in 100 Mbps mode.

Only the bench scenarios can show the following. The exact grant delay after busy carrier. The two-part gap boundary. The excessive-deferral threshold at its exact edge. The collision counts leading up to the retry limit. The SQE window in both outcomes. The truncate-versus-bad-FCS choice around the slot boundary.

// File: rtl/tx_defer_tracker.sv
module tx_defer_tracker #(
  parameter int IPG_BITS    = 96,
  parameter int SLOT_BITS   = 512,
  parameter int RETRY_LIMIT = 16,
  parameter int EXDEF_BITS  = 24288,
  parameter int SQE_WIN     = 40,
  parameter int BO_CAP      = 10
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  tx_req,
  input  logic                                  crs,
  input  logic                                  col,
  input  logic                                  tx_end,
  input  logic                                  fifo_underrun,
  input  logic                                  mode_10m,
  input  logic                                  two_part,
  input  logic                                  sqe_pulse,
  output logic                                  tx_grant,
  output logic [1:0]                            tx_corrupt,
  output logic                                  stat_done,
  output logic [8+$clog2(RETRY_LIMIT+1)-1:0]    tx_stat
);

  localparam int GW = $clog2(IPG_BITS);
  localparam int DW = $clog2(EXDEF_BITS + 1);
  localparam int XW = $clog2(SLOT_BITS + 1);
  localparam int QW = $clog2(SQE_WIN);
  localparam int CW = $clog2(RETRY_LIMIT + 1);
  localparam int BW = $clog2(SLOT_BITS) + BO_CAP + 1;

  localparam logic [GW-1:0] GAP_LAST = GW'(IPG_BITS - 1);
  localparam logic [GW-1:0] GAP_P1   = GW'(IPG_BITS * 2 / 3);
  localparam logic [DW-1:0] DLY_LIM  = DW'(EXDEF_BITS);
  localparam logic [XW-1:0] SLOT_L   = XW'(SLOT_BITS);
  localparam logic [QW-1:0] SQE_LAST = QW'(SQE_WIN - 1);
  localparam logic [CW-1:0] RTY_L    = CW'(RETRY_LIMIT);

  localparam logic [1:0] C_NONE = 2'b00;
  localparam logic [1:0] C_RUNT = 2'b01;
  localparam logic [1:0] C_BFCS = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_DEFER, S_XMIT, S_BACK, S_SQE, S_DONE} state_t;

  state_t            state;
  logic [GW-1:0]     gap_cnt;
  logic [DW-1:0]     dly_cnt;
  logic [XW-1:0]     xmit_cnt;
  logic [QW-1:0]     sqe_cnt;
  logic [BW-1:0]     bo_cnt;
  logic [BO_CAP-1:0] fr_cnt;
  logic [CW-1:0]     ncol;
  logic              launched, crs_q, m10_q;
  logic              f_def, f_exdef, f_lcar, f_lcol, f_cerr, f_rtry;

  logic [CW-1:0]     ncol_nx;
  logic [BO_CAP-1:0] bo_mask;
  logic [BW-1:0]     bo_load;
  logic              gap_hit, is_late, r_one, r_more;

  assign ncol_nx = ncol + CW'(1);
  assign bo_mask = (int'(ncol_nx) >= BO_CAP) ? '1 : ((BO_CAP'(1) << ncol_nx) - BO_CAP'(1));
  assign bo_load = BW'(fr_cnt & bo_mask) * BW'(SLOT_BITS);
  assign gap_hit = crs && !(two_part && gap_cnt >= GAP_P1);
  assign is_late = xmit_cnt >= SLOT_L;

  assign r_one  = (ncol == CW'(1)) && !f_rtry;
  assign r_more = (ncol >  CW'(1)) && !f_rtry;

  assign tx_grant  = (state == S_XMIT);
  assign stat_done = (state == S_DONE);
  assign tx_stat   = {ncol, f_rtry, r_more, r_one, f_cerr, f_lcol, f_lcar, f_exdef, f_def};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      gap_cnt <= '0; dly_cnt <= '0; xmit_cnt <= '0; sqe_cnt <= '0; bo_cnt <= '0;
      fr_cnt <= '0; ncol <= '0; launched <= 1'b0; crs_q <= 1'b0; m10_q <= 1'b0;
      f_def <= 1'b0; f_exdef <= 1'b0; f_lcar <= 1'b0; f_lcol <= 1'b0;
      f_cerr <= 1'b0; f_rtry <= 1'b0; tx_corrupt <= C_NONE;
    end else begin
      fr_cnt <= fr_cnt + BO_CAP'(1);
      crs_q  <= crs;
      case (state)
        S_IDLE: if (tx_req) begin
          state <= S_DEFER;
          gap_cnt <= '0; dly_cnt <= '0; ncol <= '0; launched <= 1'b0;
          m10_q <= mode_10m; tx_corrupt <= C_NONE;
          f_def <= crs; f_exdef <= 1'b0; f_lcar <= 1'b0;
          f_lcol <= 1'b0; f_cerr <= 1'b0; f_rtry <= 1'b0;
        end
        S_DEFER: begin
          if (!launched) begin
            if (dly_cnt == DLY_LIM) f_exdef <= 1'b1;
            else dly_cnt <= dly_cnt + DW'(1);
          end
          if (crs) f_def <= 1'b1;
          if (gap_hit) gap_cnt <= '0;
          else if (gap_cnt == GAP_LAST) begin
            state <= S_XMIT; xmit_cnt <= '0; launched <= 1'b1;
          end else gap_cnt <= gap_cnt + GW'(1);
        end
        S_XMIT: begin
          if (xmit_cnt != SLOT_L) xmit_cnt <= xmit_cnt + XW'(1);
          if (crs_q && !crs && !col) f_lcar <= 1'b1;
          if (col) begin
            tx_corrupt <= C_NONE;
            if (is_late) begin
              f_lcol <= 1'b1; state <= S_DONE;
            end else begin
              ncol <= ncol_nx;
              if (ncol_nx == RTY_L) begin
                f_rtry <= 1'b1; state <= S_DONE;
              end else begin
                state <= S_BACK; bo_cnt <= bo_load;
              end
            end
          end else if (tx_end || tx_corrupt == C_RUNT) begin
            tx_corrupt <= C_NONE; sqe_cnt <= '0;
            state <= m10_q ? S_SQE : S_DONE;
          end else if (fifo_underrun && tx_corrupt == C_NONE) begin
            tx_corrupt <= is_late ? C_BFCS : C_RUNT;
          end
        end
        S_BACK: begin
          if (bo_cnt == '0) begin
            state <= S_DEFER; gap_cnt <= '0;
          end else bo_cnt <= bo_cnt - BW'(1);
        end
        S_SQE: begin
          if (sqe_pulse) state <= S_DONE;
          else if (sqe_cnt == SQE_LAST) begin
            f_cerr <= 1'b1; state <= S_DONE;
          end else sqe_cnt <= sqe_cnt + QW'(1);
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_quiet_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_grant) && !$past(two_part) |-> !$past(crs));

  assert_late_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant && col && is_late |=> !tx_grant && stat_done && tx_stat[3]);

  assert_retry_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_done |-> $onehot0(tx_stat[7:5]));

  assert_no_sqe_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_done && !m10_q |-> !tx_stat[4]);

  assert_underrun_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant && fifo_underrun && !col && !tx_end && tx_corrupt == C_NONE |=> tx_corrupt != C_NONE);

  assert_corrupt_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_corrupt != C_NONE |-> tx_grant);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_done |=> !stat_done);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && !tx_req |=> $stable(tx_stat));

endmodule

// File: tb/tx_defer_tracker_bench.sv
module tx_defer_tracker_bench;
  localparam int IPG = 12, SLOT = 40, LIM = 5, EXD = 200, SQW = 20;
  localparam int CW = $clog2(LIM + 1);
  localparam int SW = 8 + CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_req = 0, crs = 0, col = 0, tx_end = 0, fifo_underrun = 0;
  logic mode_10m = 0, two_part = 0, sqe_pulse = 0;
  logic tx_grant, stat_done;
  logic [1:0] tx_corrupt;
  logic [SW-1:0] tx_stat;
  int nvec = 0, nbad = 0;

  always #10 clk = ~clk;

  tx_defer_tracker #(.IPG_BITS(IPG), .SLOT_BITS(SLOT), .RETRY_LIMIT(LIM),
                     .EXDEF_BITS(EXD), .SQE_WIN(SQW), .BO_CAP(10)) u_tx_defer_tracker (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .crs(crs), .col(col), .tx_end(tx_end),
    .fifo_underrun(fifo_underrun), .mode_10m(mode_10m), .two_part(two_part),
    .sqe_pulse(sqe_pulse), .tx_grant(tx_grant), .tx_corrupt(tx_corrupt),
    .stat_done(stat_done), .tx_stat(tx_stat));

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string what, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int exp_wait(input int pb);
    return ((pb > 1) ? pb : 1) + IPG;
  endfunction

  function automatic logic [SW-1:0] exp_stat(input bit dfd, input int k, input int ncol,
      input bit late, input bit drop, input bit m10, input bit sqe);
    logic [SW-1:0] s;
    bit rt;
    int c;
    rt = (ncol >= LIM);
    c  = rt ? LIM : ncol;
    s = '0;
    s[0] = dfd;
    s[1] = (k - 1) > EXD;
    s[2] = drop && !rt && !late;
    s[3] = late && !rt;
    s[4] = m10 && !sqe && !rt && !late;
    s[5] = (c == 1) && !rt;
    s[6] = (c > 1) && !rt;
    s[7] = rt;
    s[8 +: CW] = CW'(c);
    return s;
  endfunction

  task automatic tail(input bit drop, input bit m10, input bit sqe);
    repeat (SLOT / 2) tick;
    if (drop) crs = 0;
    repeat (SLOT / 2 + 10) tick;
    tx_end = 1; tick; tx_end = 0; crs = 0;
    if (m10 && sqe) begin tick; sqe_pulse = 1; tick; sqe_pulse = 0; end
  endtask

  task automatic wait_done;
    int g;
    g = 0;
    while (!stat_done && g < 4000) begin tick; g++; end
  endtask

  task automatic check_stat(input logic [SW-1:0] e);
    logic [SW-1:0] st;
    st = tx_stat;
    chk("R10 done strobe", int'(stat_done), 1);
    chk("R4 defer bits", int'(st[1:0]), int'(e[1:0]));
    chk("R5 loss of carrier", int'(st[2]), int'(e[2]));
    chk("R6 late collision", int'(st[3]), int'(e[3]));
    chk("R8 sqe error", int'(st[4]), int'(e[4]));
    chk("R7 retry class/count", int'(st[SW-1:5]), int'(e[SW-1:5]));
    tick;
    chk("R10 done one cycle", int'(stat_done), 0);
    chk("R10 status held", int'(tx_stat), int'(st));
  endtask

  task automatic send(input int pb, input int ncol, input bit late, input bit drop,
                      input bit m10, input bit sqe);
    int cyc, att, g, k;
    bit fin;
    mode_10m = m10; two_part = 0; crs = (pb > 0); tx_req = 1;
    tick; tx_req = 0; cyc = 1;
    if (pb == 0) chk("R10 cleared on accept", int'(tx_stat), 0);
    if (cyc >= pb) crs = 0;
    while (!tx_grant && cyc < 3000) begin tick; cyc++; if (cyc >= pb) crs = 0; end
    k = cyc;
    chk("R2 grant delay", k, exp_wait(pb));
    att = 0; fin = 0;
    while (!fin) begin
      crs = 1;
      if (att < ncol) begin
        tick; tick; col = 1; tick; col = 0; crs = 0; att++;
        g = 0;
        while (!tx_grant && !stat_done && g < 3000) begin tick; g++; end
        if (!tx_grant) fin = 1;
      end else if (late) begin
        repeat (SLOT + 4) tick; col = 1; tick; col = 0; crs = 0; fin = 1;
      end else begin
        tail(drop, m10, sqe); fin = 1;
      end
    end
    wait_done;
    check_stat(exp_stat(pb > 0, exp_wait(pb), ncol, late, drop, m10, sqe));
  endtask

  task automatic probe(input bit two, input int j, input int expk);
    int cyc;
    two_part = two; mode_10m = 0; crs = 0; tx_req = 1;
    tick; tx_req = 0; cyc = 1;
    while (!tx_grant && cyc < 500) begin
      crs = (cyc == j - 1);
      tick; cyc++;
    end
    chk("R3 split gap grant", cyc, expk);
    crs = 1; tail(0, 0, 0); wait_done;
    chk("R4 deferred on gap carrier", int'(tx_stat[0]), 1);
    tick; two_part = 0;
  endtask

  task automatic grab;
    int g;
    crs = 0; tx_req = 1; tick; tx_req = 0; g = 0;
    while (!tx_grant && g < 500) begin tick; g++; end
  endtask

  initial begin
    int sel, pb, nc;
    bit lt, dr, m, sq;
    void'($urandom(32'd1234));
    repeat (3) tick;
    chk("R1 grant in reset", int'(tx_grant), 0);
    chk("R1 corrupt in reset", int'(tx_corrupt), 0);
    rst_n = 1; tick;
    chk("R1 done after reset", int'(stat_done), 0);
    chk("R1 status after reset", int'(tx_stat), 0);
    chk("R1 grant after reset", int'(tx_grant), 0);

    send(0, 0, 0, 0, 0, 0);
    send(1, 0, 0, 0, 0, 0);
    send(25, 0, 0, 0, 0, 0);
    send(189, 0, 0, 0, 0, 0);
    send(190, 0, 0, 0, 0, 0);
    probe(1, 3, 3 + IPG);
    probe(1, 9, 9 + IPG);
    probe(1, 10, IPG + 1);
    probe(1, 12, IPG + 1);
    probe(0, 10, 10 + IPG);
    send(0, 0, 0, 1, 0, 0);
    send(0, 0, 1, 0, 0, 0);
    send(0, 2, 1, 0, 0, 0);
    send(0, 1, 0, 0, 0, 0);
    send(0, 2, 0, 0, 0, 0);
    send(0, LIM - 1, 0, 0, 0, 0);
    send(0, LIM, 0, 0, 1, 0);
    send(0, LIM + 1, 0, 0, 0, 0);
    send(0, 0, 0, 0, 1, 0);
    send(0, 0, 0, 0, 1, 1);
    send(0, 0, 0, 0, 0, 0);

    mode_10m = 0; grab; crs = 1;
    repeat (4) tick; fifo_underrun = 1; tick; fifo_underrun = 0;
    chk("R9 truncate command", int'(tx_corrupt), 1);
    chk("R9 grant during truncate", int'(tx_grant), 1);
    tick;
    chk("R9 grant drops after truncate", int'(tx_grant), 0);
    chk("R9 command cleared", int'(tx_corrupt), 0);
    crs = 0; wait_done; tick;

    grab; crs = 1;
    repeat (SLOT + 5) tick; fifo_underrun = 1; tick; fifo_underrun = 0;
    chk("R9 bad fcs command", int'(tx_corrupt), 2);
    repeat (3) tick; fifo_underrun = 1; tick; fifo_underrun = 0; tick;
    chk("R9 bad fcs held", int'(tx_corrupt), 2);
    chk("R9 grant held", int'(tx_grant), 1);
    tx_end = 1; tick; tx_end = 0; crs = 0;
    chk("R9 cleared at end", int'(tx_corrupt), 0);
    wait_done; tick;

    for (int i = 0; i < 30; i++) begin
      sel = int'($urandom % 4);
      pb = (sel == 0) ? 0 : (sel == 1) ? 1 + int'($urandom % 30)
         : (sel == 2) ? 300 + int'($urandom % 100) : 2 + int'($urandom % 8);
      nc = int'($urandom % (LIM + 2));
      lt = ($urandom % 4) == 0;
      dr = ($urandom % 4) == 0;
      m  = $urandom % 2;
      sq = $urandom % 2;
      send(pb, nc, lt, dr, m, sq);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule